// File: doc/BRIEF.md
# Fixed-Point DC Motor Speed Plant

This block is a hardware stand-in for a small DC motor. Software writes a command voltage and reads back the shaft speed. Between those two values sits a second-order recursive filter in direct form I. It uses constant quantized coefficients and produces the motor's speed response. Both values are signed 32-bit two's complement numbers with 16 fraction bits.

An internal divider produces a one-cycle sample strobe. The default is one strobe every 25000 clocks, which is 100 µs at 250 MHz. On each strobe the filter takes the current voltage register value as its new input sample. It then computes one output in a single clock, rounds it, clamps it, and stores it both in its feedback history and in the speed register.

Both registers sit behind a minimal AXI4-Lite slave. Software that drives this model sees the same stepwise dynamic behaviour it would see from a real motor sampled at the same rate.

Top module: `motor_biquad_plant`

## Requirements
- R1: A synchronous active-high reset clears the voltage register, the speed register and all four delay elements to zero.
- R2: The sample strobe fires once every TICK_CYCLES clocks. The speed register changes only in the clock that follows a strobe. With the counter cleared by reset, updates occur TICK_CYCLES+1 clocks after reset release and every TICK_CYCLES clocks after that.
- R3: Each new output is y = (1475·x[n] + 2950·x[n-1] + 1475·x[n-2] + 1694·y[n-1] + 63677·y[n-2]) / 2^16. This comes from feedback coefficients of −1694 and −63677 (scale 2^-16) that are subtracted. The sum is formed without overflow in a 56-bit accumulator.
- R4: The 2^-16 scaling rounds to nearest with ties toward +∞. It adds 2^15 and then shifts right arithmetically by 16.
- R5: The rounded result is clamped to [−2^31, 2^31−1] before it enters the speed register and the y[n-1] history.
- R6: Offset 0x0 holds the voltage register. It is readable and writable, and each of the four write-strobe bits updates its own byte (strobe bit i covers data bits 8i+7..8i).
- R7: Offset 0x4 returns the speed register. Writes to it answer OKAY (bresp 2'b00) and change nothing.
- R8: Any other address, including unaligned ones, answers SLVERR (2'b10). Such reads return zero and such writes change nothing.
- R9: The filter input is the voltage register value at the strobe. A voltage write between strobes does not change the speed until the next update.
- R10: Once raised, bvalid stays high until bready is seen. Once raised, rvalid stays high with rdata stable until rready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response accepted |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data accepted |

## Verification
The filter is driven through a sequence of voltage patterns, and every output is compared against an integer model of the difference equation:
- A positive step and a negative step show the slow settling and the ringing from the near-unity pole pair.
- A return to zero shows that the stored history alone drives the output.
- An input with odd fraction bits exposes any rounding error.
- Long full-scale positive and full-scale negative runs push the output into both clamps. They also show that the clamped value, not the raw one, is fed back.

Mid-period writes to voltage, to speed and to unmapped addresses, plus a partial-strobe write, separate sampling-at-strobe, read-only and error-response behaviour.

// File: rtl/mbp_pkg.sv
package mbp_pkg;
  localparam int SAMPLE_W = 32;
  localparam int FRAC_W   = 16;
  localparam int COEF_W   = 18;
  localparam int ACC_W    = 56;
  localparam int NTAP     = 3;
  localparam int STRB_W   = SAMPLE_W / 8;

  // feedforward taps, scaled by 2^-FRAC_W
  localparam logic signed [COEF_W-1:0] COEF_B [NTAP] = '{18'sd1475, 18'sd2950, 18'sd1475};
  // feedback taps (subtracted), scaled by 2^-FRAC_W
  localparam logic signed [COEF_W-1:0] COEF_A1 = -18'sd1694;
  localparam logic signed [COEF_W-1:0] COEF_A2 = -18'sd63677;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_SLVERR = 2'b10
  } axi_resp_e;

  typedef enum logic [1:0] {
    SEL_VOLT,
    SEL_SPEED,
    SEL_NONE
  } reg_sel_e;

  function automatic logic signed [SAMPLE_W-1:0] clamp_sample(input logic signed [ACC_W-1:0] v);
    logic signed [ACC_W-1:0] hi;
    logic signed [ACC_W-1:0] lo;
    hi = (ACC_W'(64'sd1) <<< (SAMPLE_W-1)) - ACC_W'(64'sd1);
    lo = -(ACC_W'(64'sd1) <<< (SAMPLE_W-1));
    if (v > hi)      return hi[SAMPLE_W-1:0];
    else if (v < lo) return lo[SAMPLE_W-1:0];
    else             return v[SAMPLE_W-1:0];
  endfunction
endpackage

// File: rtl/mbp_tick_gen.sv
module mbp_tick_gen #(
  parameter int unsigned TICK_CYCLES = 25000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mbp_biquad_core.sv
module mbp_biquad_core
  import mbp_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick,
  input  logic signed [SAMPLE_W-1:0] x_in,
  output logic signed [SAMPLE_W-1:0] y_out
);
  localparam logic signed [ACC_W-1:0] RND_BIAS = ACC_W'(64'sd1 <<< (FRAC_W-1));

  logic signed [SAMPLE_W-1:0] x_d [1:NTAP-1];
  logic signed [SAMPLE_W-1:0] y_d1, y_d2;
  logic signed [ACC_W-1:0]    acc, rnd;
  logic signed [SAMPLE_W-1:0] y_next;

  always_comb begin
    acc = ACC_W'(x_in) * ACC_W'(COEF_B[0]);
    for (int k = 1; k < NTAP; k++) begin
      acc = acc + ACC_W'(x_d[k]) * ACC_W'(COEF_B[k]);
    end
    acc    = acc - ACC_W'(y_d1) * ACC_W'(COEF_A1);
    acc    = acc - ACC_W'(y_d2) * ACC_W'(COEF_A2);
    rnd    = (acc + RND_BIAS) >>> FRAC_W;
    y_next = clamp_sample(rnd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 1; k < NTAP; k++) x_d[k] <= '0;
      y_d1  <= '0;
      y_d2  <= '0;
      y_out <= '0;
    end else if (tick) begin
      x_d[1] <= x_in;
      for (int k = 2; k < NTAP; k++) x_d[k] <= x_d[k-1];
      y_d1  <= y_next;
      y_d2  <= y_d1;
      y_out <= y_next;
    end
  end
endmodule

// File: rtl/mbp_axil_regs.sv
module mbp_axil_regs
  import mbp_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   awaddr,
  input  logic                awvalid,
  output logic                awready,
  input  logic [SAMPLE_W-1:0] wdata,
  input  logic [STRB_W-1:0]   wstrb,
  input  logic                wvalid,
  output logic                wready,
  output logic [1:0]          bresp,
  output logic                bvalid,
  input  logic                bready,
  input  logic [ADDR_W-1:0]   araddr,
  input  logic                arvalid,
  output logic                arready,
  output logic [SAMPLE_W-1:0] rdata,
  output logic [1:0]          rresp,
  output logic                rvalid,
  input  logic                rready,
  input  logic [SAMPLE_W-1:0] speed,
  output logic [SAMPLE_W-1:0] volt
);
  localparam logic [ADDR_W-1:0] OFS_VOLT  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_SPEED = ADDR_W'(4);

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == OFS_VOLT)       return SEL_VOLT;
    else if (a == OFS_SPEED) return SEL_SPEED;
    else                     return SEL_NONE;
  endfunction

  reg_sel_e wsel, rsel;
  logic     wr_go, rd_go;

  assign wsel  = decode(awaddr);
  assign rsel  = decode(araddr);
  assign wr_go = awvalid && wvalid && !awready && !bvalid;
  assign rd_go = arvalid && !arready && !rvalid;

  always_ff @(posedge clk) begin
    if (rst) begin
      awready <= 1'b0;
      wready  <= 1'b0;
      bvalid  <= 1'b0;
      bresp   <= RESP_OKAY;
      volt    <= '0;
    end else begin
      awready <= wr_go;
      wready  <= wr_go;
      if (wr_go) begin
        bvalid <= 1'b1;
        bresp  <= (wsel == SEL_NONE) ? RESP_SLVERR : RESP_OKAY;
        if (wsel == SEL_VOLT) begin
          for (int b = 0; b < STRB_W; b++) begin
            if (wstrb[b]) volt[8*b +: 8] <= wdata[8*b +: 8];
          end
        end
      end else if (bvalid && bready) begin
        bvalid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arready <= 1'b0;
      rvalid  <= 1'b0;
      rdata   <= '0;
      rresp   <= RESP_OKAY;
    end else begin
      arready <= rd_go;
      if (rd_go) begin
        rvalid <= 1'b1;
        unique case (rsel)
          SEL_VOLT:  begin rdata <= volt;  rresp <= RESP_OKAY;   end
          SEL_SPEED: begin rdata <= speed; rresp <= RESP_OKAY;   end
          default:   begin rdata <= '0;    rresp <= RESP_SLVERR; end
        endcase
      end else if (rvalid && rready) begin
        rvalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/motor_biquad_plant.sv
module motor_biquad_plant
  import mbp_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 25000,
  parameter int          ADDR_W      = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [SAMPLE_W-1:0] s_wdata,
  input  logic [STRB_W-1:0]   s_wstrb,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [1:0]          s_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic                s_arvalid,
  output logic                s_arready,
  output logic [SAMPLE_W-1:0] s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rvalid,
  input  logic                s_rready
);
  logic                       tick;
  logic [SAMPLE_W-1:0]        volt_q;
  logic signed [SAMPLE_W-1:0] speed_q;

  mbp_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  mbp_biquad_core u_core (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .x_in  ($signed(volt_q)),
    .y_out (speed_q)
  );

  mbp_axil_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .awaddr  (s_awaddr),
    .awvalid (s_awvalid),
    .awready (s_awready),
    .wdata   (s_wdata),
    .wstrb   (s_wstrb),
    .wvalid  (s_wvalid),
    .wready  (s_wready),
    .bresp   (s_bresp),
    .bvalid  (s_bvalid),
    .bready  (s_bready),
    .araddr  (s_araddr),
    .arvalid (s_arvalid),
    .arready (s_arready),
    .rdata   (s_rdata),
    .rresp   (s_rresp),
    .rvalid  (s_rvalid),
    .rready  (s_rready),
    .speed   (speed_q),
    .volt    (volt_q)
  );
endmodule

// File: rtl/mbp_checker.sv
module mbp_checker (
  input logic        clk,
  input logic        rst,
  input logic        tick,
  input logic [31:0] speed,
  input logic [31:0] volt,
  input logic        bvalid,
  input logic        bready,
  input logic        rvalid,
  input logic        rready,
  input logic [31:0] rdata
);
  // R1: first cycle out of reset sees cleared registers
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (speed == 32'd0 && volt == 32'd0));

  // R2: speed moves only right after a strobe
  p_speed_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(speed));

  // R2: strobe is a single-cycle pulse
  p_tick_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R10: write response held until accepted
  p_bvalid_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (bvalid && !bready) |=> bvalid);

  // R10: read data held until accepted
  p_rvalid_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));
endmodule

bind motor_biquad_plant mbp_checker u_mbp_checker (
  .clk    (clk),
  .rst    (rst),
  .tick   (tick),
  .speed  (speed_q),
  .volt   (volt_q),
  .bvalid (s_bvalid),
  .bready (s_bready),
  .rvalid (s_rvalid),
  .rready (s_rready),
  .rdata  (s_rdata)
);

// File: tb/tb_motor_biquad_plant.sv
`timescale 1ns/1ps
module tb_motor_biquad_plant;
  localparam int TICK   = 64;
  localparam int AW     = 4;
  localparam int NSTEPS = 136;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;

  always #2 clk = ~clk; // 250 MHz

  motor_biquad_plant #(.TICK_CYCLES(TICK), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready)
  );

  int checks = 0, errors = 0, cyc = 0, sat_hits = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  logic [31:0] vreg = '0, last_exp = '0;
  longint mx1 = 0, mx2 = 0, my1 = 0, my2 = 0;

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic wait_cyc(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic axi_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s,
                           output logic [1:0] r);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
    do @(negedge clk); while (!awready);
    awvalid = 0; wvalid = 0;
    r = bresp;
    check(bvalid, "R10 bvalid", {31'd0, bvalid}, 32'd1);
    @(negedge clk);
    check(bvalid && bresp == r, "R10 bvalid hold", {31'd0, bvalid}, 32'd1);
    bready = 1;
    @(negedge clk);
    bready = 0;
  endtask

  task automatic axi_read(input logic [AW-1:0] a, output logic [31:0] d, output logic [1:0] r);
    @(negedge clk);
    araddr = a; arvalid = 1;
    do @(negedge clk); while (!arready);
    arvalid = 0;
    d = rdata; r = rresp;
    @(negedge clk);
    check(rvalid && rdata == d, "R10 rdata hold", rdata, d);
    rready = 1;
    @(negedge clk);
    rready = 0;
  endtask

  // reference model of one filter update (R3, R4, R5); pushes the expected speed
  task automatic model_push(input logic [31:0] xin);
    longint x0, acc, r;
    x0  = longint'($signed(xin));
    acc = 1475 * x0 + 2950 * mx1 + 1475 * mx2 + 1694 * my1 + 63677 * my2;
    r   = (acc + 32768) >>> 16;
    if (r > 64'sd2147483647)       begin r = 64'sd2147483647;  sat_hits++; end
    else if (r < -64'sd2147483648) begin r = -64'sd2147483648; sat_hits++; end
    mx2 = mx1; mx1 = x0; my2 = my1; my1 = r;
    last_exp = r[31:0];
    exp_q.push_back(r[31:0]);
  endtask

  function automatic logic [31:0] pattern(input int n);
    if (n < 12)       return 32'h0005_0000; // +5.0 step
    else if (n < 20)  return 32'hFFFD_0000; // -3.0 step
    else if (n < 24)  return 32'h0000_0000; // release
    else if (n < 28)  return 32'h0001_2345; // odd fraction bits
    else if (n < 76)  return 32'h7FFF_FFFF; // full scale positive
    else if (n < 132) return 32'h8000_0000; // full scale negative
    else              return 32'h0000_0000;
  endfunction

  // driver: mid-period register traffic, then push expected result of next update
  task automatic driver();
    logic [31:0] d;
    logic [1:0]  r;
    for (int n = 0; n < NSTEPS; n++) begin
      wait_cyc(TICK + 1 + n * TICK - TICK / 2);
      if (n == 2) begin
        axi_write(4'h4, 32'hDEAD_BEEF, 4'hF, r);
        check(r == 2'b00, "R7 speed write bresp", {30'd0, r}, 32'd0);
        axi_read(4'h4, d, r);
        check(d == last_exp, "R7 speed write ignored", d, last_exp);
      end
      if (n == 3) begin
        axi_write(4'h8, 32'h1234_5678, 4'hF, r);
        check(r == 2'b10, "R8 bad write SLVERR", {30'd0, r}, 32'd2);
        axi_read(4'hC, d, r);
        check(r == 2'b10, "R8 bad read SLVERR", {30'd0, r}, 32'd2);
        check(d == 32'd0, "R8 bad read data", d, 32'd0);
        axi_read(4'h1, d, r);
        check(r == 2'b10, "R8 unaligned read SLVERR", {30'd0, r}, 32'd2);
        axi_read(4'h0, d, r);
        check(d == vreg, "R8 bad write no effect", d, vreg);
      end
      if (n == 4) begin
        axi_write(4'h0, 32'hAABB_CCDD, 4'b0010, r);
        vreg[15:8] = 8'hCC;
        axi_read(4'h0, d, r);
        check(d == vreg && r == 2'b00, "R6 byte strobe", d, vreg);
      end else begin
        axi_write(4'h0, pattern(n), 4'hF, r);
        vreg = pattern(n);
        check(r == 2'b00, "R6 voltage write bresp", {30'd0, r}, 32'd0);
      end
      axi_read(4'h4, d, r);
      check(d == last_exp, "R9 write waits for next tick", d, last_exp);
      model_push(vreg);
    end
  endtask

  // monitor: read speed right after each update and compare with scoreboard
  task automatic monitor();
    logic [31:0] d, e;
    logic [1:0]  r;
    for (int n = 0; n < NSTEPS; n++) begin
      wait_cyc(TICK + 1 + n * TICK + 2);
      axi_read(4'h4, d, r);
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 scoreboard empty", d, 32'd0);
      end else begin
        e = exp_q.pop_front();
        check(d == e && r == 2'b00, "R3/R4/R5 speed sample", d, e);
      end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    logic [31:0] d;
    logic [1:0]  r;
    repeat (4) @(negedge clk);
    rst = 0;
    axi_read(4'h0, d, r);
    check(d == 32'd0, "R1 voltage after reset", d, 32'd0);
    axi_read(4'h4, d, r);
    check(d == 32'd0, "R1 speed after reset", d, 32'd0);
    fork
      driver();
      monitor();
    join
    check(sat_hits > 0, "R5 clamp reached", sat_hits, 32'd1);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule